// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns single characters written by a host into asynchronous serial frames on a one-bit output. A write strobe with an 8-bit value loads a one-entry holding register. When the frame engine is free, the character moves into a shifter one clock later. The shifter sends a low start bit, then the data bits least-significant first, then an optional parity bit, then a high stop interval. The line rests high between frames.

Static control inputs set the frame shape: character length (5 to 8 bits), parity (off, even, odd, or a fixed "stick" value), and stop length (1, 1.5 or 2 bit times). Two further controls are a break request, which pulls the line low and stops new characters from starting, and a loopback select, which sends the frame to a local receiver pin instead of the external line. Bit timing comes from a 16-bit divisor that produces a 16x oversampling tick. One bit lasts 16 ticks, so a bit lasts 16 × divisor clock cycles. Two flags report whether the holding register is free and whether the transmitter is fully quiet.

Top module: `serial_tx_core`

## Requirements
- R1: After reset, `ser_out` and `loop_out` are 1 (mark), and `hold_empty` and `tx_idle` are both 1.
- R2: A frame is a 0 start bit, then the data bits least-significant first, then the stop interval at 1. `len_code` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits.
- R3: With `par_en`=0 no parity bit is sent, and the stop interval follows the last data bit at once.
- R4: With `par_en`=1 and `par_stick`=0, one parity bit follows the data. `par_even`=1 makes the number of ones in data plus parity even; `par_even`=0 makes it odd.
- R5: With `par_en`=1 and `par_stick`=1, the parity bit equals `par_even`.
- R6: The stop interval lasts 16 ticks when `stop_long`=0. When `stop_long`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for any other length. `tx_idle` rises at the end of the stop interval when nothing is waiting.
- R7: One tick lasts `divisor` clock cycles, and a divisor of 0 acts as 1. Every start, data and parity bit lasts 16 ticks, and the frame starts in step with the tick count.
- R8: While `brk`=1 the active output is 0 and no waiting character enters the shifter (`hold_empty` stays 0). After `brk` falls, the line marks for one cycle and then the waiting character starts.
- R9: A write while the transmitter is idle clears `hold_empty` for one cycle. On the next clock the character enters the shifter, `hold_empty` returns to 1 and `tx_idle` stays 0 until the frame ends.
- R10: A write while the holding register is full replaces the waiting character. A waiting character starts one cycle after the previous stop interval ends.
- R11: With `loop_sel`=1 the frame appears on `loop_out` and `ser_out` stays at 1. With `loop_sel`=0, `loop_out` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| divisor | input | 16 | Tick period in clock cycles (0 treated as 1) |
| len_code | input | 2 | Character length code, 0..3 → 5..8 bits |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select, or the stick value |
| par_stick | input | 1 | Fixed-value parity select |
| stop_long | input | 1 | Long stop interval select |
| brk | input | 1 | Break request: hold line low, start nothing |
| loop_sel | input | 1 | Route frames to `loop_out` instead of `ser_out` |
| ser_out | output | 1 | External serial line |
| loop_out | output | 1 | Local loopback line |
| hold_empty | output | 1 | Holding register has no waiting character |
| tx_idle | output | 1 | Nothing waiting and shifter idle |

## Verification
The frame engine is driven with several character lengths and data patterns. Each data bit is sampled at its centre, so bit order errors and length-code errors show up as distinct mismatches. Parity is tried even, odd, stick-high and stick-low on data with odd and even numbers of ones, which separates a swapped even/odd sense from a stick bit that follows the data. Frame length is checked against divisors of 0, 1, 2 and 3 and all three stop lengths, which exposes both tick-rate and stop-count faults. Separate sequences cover a back-to-back overwrite of the holding register, a break held across a pending write, and loopback routing with the idle pin watched throughout.

// File: rtl/tx_pkg.sv
package tx_pkg;

  localparam int CHAR_MAX = 8;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } tx_phase_t;

  // Length code 0..3 selects 5..8 data bits
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // Parity bit for the character under the given controls
  function automatic logic frame_parity(input logic [CHAR_MAX-1:0] d,
                                        input logic [1:0] code,
                                        input logic even,
                                        input logic stick);
    logic [CHAR_MAX-1:0] mask;
    logic ones_odd;
    mask = {CHAR_MAX{1'b1}} >> (2'd3 - code);
    ones_odd = ^(d & mask);
    if (stick) return even;
    return even ? ones_odd : ~ones_odd;
  endfunction

endpackage

// File: rtl/tx_baud_gen.sv
module tx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb lim = (divisor == '0) ? '0 : divisor - 1'b1;

  assign tick = !restart && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart)   cnt <= '0;
    else if (cnt >= lim)  cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic [W-1:0] data,
  output logic         full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr) data <= wdata;
      if (wr)        full <= 1'b1;
      else if (take) full <= 1'b0;
    end
  end

  assert_take_needs_full_R9: assert property (@(posedge clk) disable iff (rst)
    take |-> full);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import tx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int TCNT_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                load,
  input  logic [CHAR_MAX-1:0] data,
  input  logic [3:0]          nbits,
  input  logic                par_on,
  input  logic                par_val,
  input  logic [TCNT_W-1:0]   stop_ticks,
  output logic                line,
  output logic                busy
);
  localparam logic [TCNT_W-1:0] BIT_LAST = TCNT_W'(OVS - 1);
  localparam logic [TCNT_W-1:0] TCNT_CAP = TCNT_W'(2 * OVS);

  tx_phase_t           phase;
  logic [CHAR_MAX-1:0] shreg;
  logic [3:0]          bitcnt;
  logic [3:0]          nb_r;
  logic                pon_r, pv_r;
  logic [TCNT_W-1:0]   st_r;
  logic [TCNT_W-1:0]   tcnt;
  logic [TCNT_W-1:0]   seg_last;
  logic                seg_end;

  always_comb begin
    seg_last = (phase == PH_STOP) ? st_r - 1'b1 : BIT_LAST;
    seg_end  = tick && (tcnt == seg_last);
  end

  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      nb_r   <= 4'd5;
      pon_r  <= 1'b0;
      pv_r   <= 1'b0;
      st_r   <= TCNT_W'(OVS);
      tcnt   <= '0;
      line   <= 1'b1;
    end else if (load) begin
      phase  <= PH_START;
      shreg  <= data;
      bitcnt <= '0;
      nb_r   <= nbits;
      pon_r  <= par_on;
      pv_r   <= par_val;
      st_r   <= stop_ticks;
      tcnt   <= '0;
      line   <= 1'b0;
    end else if (busy && tick) begin
      if (!seg_end) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        unique case (phase)
          PH_START: begin
            phase  <= PH_DATA;
            line   <= shreg[0];
            shreg  <= shreg >> 1;
            bitcnt <= '0;
          end
          PH_DATA: begin
            if (bitcnt == nb_r - 1'b1) begin
              if (pon_r) begin
                phase <= PH_PARITY;
                line  <= pv_r;
              end else begin
                phase <= PH_STOP;
                line  <= 1'b1;
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
              line   <= shreg[0];
              shreg  <= shreg >> 1;
            end
          end
          PH_PARITY: begin
            phase <= PH_STOP;
            line  <= 1'b1;
          end
          PH_STOP: begin
            phase <= PH_IDLE;
            line  <= 1'b1;
          end
          default: begin
            phase <= PH_IDLE;
            line  <= 1'b1;
          end
        endcase
      end
    end
  end

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> line);

  assert_start_space_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == PH_START && !line));

  assert_data_count_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA) |-> (bitcnt < nb_r));

  assert_tick_count_range_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (tcnt < TCNT_CAP));
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       len_code,
  input  logic             par_en,
  input  logic             par_even,
  input  logic             par_stick,
  input  logic             stop_long,
  input  logic             brk,
  input  logic             loop_sel,
  output logic             ser_out,
  output logic             loop_out,
  output logic             hold_empty,
  output logic             tx_idle
);
  localparam int TCNT_W = $clog2(2 * OVS) + 1;
  localparam logic [TCNT_W-1:0] STOP_ONE  = TCNT_W'(OVS);
  localparam logic [TCNT_W-1:0] STOP_HALF = TCNT_W'(OVS + OVS / 2);
  localparam logic [TCNT_W-1:0] STOP_TWO  = TCNT_W'(2 * OVS);

  logic                tick;
  logic                load;
  logic                busy;
  logic                line;
  logic                hold_full;
  logic                brk_q;
  logic [CHAR_MAX-1:0] hold_data;
  logic [TCNT_W-1:0]   stop_sel;
  logic                par_bit;
  logic                line_eff;

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= brk;
  end

  assign load = hold_full && !busy && !brk_q;

  always_comb begin
    if (!stop_long)            stop_sel = STOP_ONE;
    else if (len_code == 2'd0) stop_sel = STOP_HALF;
    else                       stop_sel = STOP_TWO;
    par_bit = frame_parity(hold_data, len_code, par_even, par_stick);
  end

  tx_hold_reg #(.W(CHAR_MAX)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_en),
    .wdata (wr_data),
    .take  (load),
    .data  (hold_data),
    .full  (hold_full)
  );

  tx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .divisor (divisor),
    .tick    (tick)
  );

  tx_frame_shifter #(.OVS(OVS), .TCNT_W(TCNT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .load       (load),
    .data       (hold_data),
    .nbits      (char_bits(len_code)),
    .par_on     (par_en),
    .par_val    (par_bit),
    .stop_ticks (stop_sel),
    .line       (line),
    .busy       (busy)
  );

  assign line_eff   = brk ? 1'b0 : line;
  assign ser_out    = loop_sel ? 1'b1 : line_eff;
  assign loop_out   = loop_sel ? line_eff : 1'b1;
  assign hold_empty = !hold_full;
  assign tx_idle    = !busy && !hold_full;

  assert_break_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (brk_q && !busy) |=> !busy);

  assert_take_empties_R9: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_en) |=> hold_empty);
endmodule

// File: tb/sim_serial_tx_core.sv
`timescale 1ns/1ps
module sim_serial_tx_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  len_code = 2'd3;
  logic        par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic        stop_long = 1'b0, brk = 1'b0, loop_sel = 1'b0;
  logic        ser_out, loop_out, hold_empty, tx_idle;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b1;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] d;
    int nb;
    bit pon;
    bit pv;
    int st;
    int dv;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  serial_tx_core u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .divisor(divisor),
    .len_code(len_code), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .stop_long(stop_long), .brk(brk), .loop_sel(loop_sel),
    .ser_out(ser_out), .loop_out(loop_out), .hold_empty(hold_empty), .tx_idle(tx_idle)
  );

  wire mline  = loop_sel ? loop_out : ser_out;
  wire oline  = loop_sel ? ser_out : loop_out;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic write_only(input logic [7:0] d, input bit hold_chk);
    @(negedge clk); #1;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    if (hold_chk) chk(hold_empty == 1'b0, "R9", "hold_empty after write", hold_empty, 0);
    #1 wr_en = 1'b0;
    if (hold_chk) begin
      @(negedge clk);
      chk(hold_empty == 1'b1, "R9", "hold_empty after move", hold_empty, 1);
      chk(tx_idle == 1'b0, "R9", "tx_idle during frame", tx_idle, 0);
    end
  endtask

  // Expected frame from the requirement text
  task automatic send(input logic [7:0] d, input bit hold_chk);
    exp_t e;
    int ones;
    e.d   = d;
    e.nb  = 5 + int'(len_code);
    e.pon = par_en;
    ones = 0;
    for (int i = 0; i < e.nb; i++) ones += int'(d[i]);
    if (par_stick) e.pv = par_even;
    else           e.pv = par_even ? (ones % 2 == 1) : (ones % 2 == 0);
    e.st  = !stop_long ? 16 : (len_code == 2'd0 ? 24 : 32);
    e.dv  = (divisor == 16'd0) ? 1 : int'(divisor);
    q.push_back(e);
    write_only(d, hold_chk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_idle && q.size() == 0));
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame();
    exp_t e;
    int f, pb, half;
    logic [7:0] got;
    bit other_bad;
    if (q.size() == 0) begin
      chk(1'b0, "R2", "unexpected frame start", 1, 0);
      return;
    end
    e = q.pop_front();
    pb = 16 * e.dv;
    half = 8 * e.dv;
    f = e.dv * (16 * (1 + e.nb + int'(e.pon)) + e.st);
    got = '0;
    other_bad = 1'b0;
    for (int cnt = 0; cnt <= f; cnt++) begin
      if (cnt > 0) @(negedge clk);
      if (oline == 1'b0) other_bad = 1'b1;
      if (cnt == half)
        chk(mline == 1'b0, "R2", "start bit", mline, 0);
      for (int k = 1; k <= e.nb; k++)
        if (cnt == pb * k + half) got[k-1] = mline;
      if (e.pon && cnt == pb * (1 + e.nb) + half)
        chk(mline == e.pv, e.pon ? "R4/R5" : "R3", "parity bit", mline, e.pv);
      if (cnt == pb * (1 + e.nb + int'(e.pon)) + half)
        chk(mline == 1'b1, "R3", "first stop sample follows data/parity", mline, 1);
      if (cnt == f - 1)
        chk(tx_idle == 1'b0 && mline == 1'b1, "R6", "still in stop interval",
            {tx_idle, mline}, 1);
      if (cnt == f) begin
        if (q.size() > 0)
          chk(hold_empty == 1'b0 && mline == 1'b1, "R10", "next char waiting at stop end",
              {hold_empty, mline}, 1);
        else
          chk(tx_idle == 1'b1, "R6/R7", "tx_idle at frame end", tx_idle, 1);
      end
    end
    chk(got == (e.d & (8'hFF >> (8 - e.nb))), "R2", "data bits LSB first",
        got, e.d & (8'hFF >> (8 - e.nb)));
    chk(!other_bad, "R11", "unused pin stayed mark", other_bad, 0);
  endtask

  // Monitor: detects a start edge and scores the frame
  initial begin
    bit prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst && mon_en && prev && !mline) begin
        run_frame();
        prev = 1'b1;
      end else begin
        prev = mline;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ser_out == 1'b1, "R1", "ser_out after reset", ser_out, 1);
    chk(loop_out == 1'b1, "R1", "loop_out after reset", loop_out, 1);
    chk(hold_empty == 1'b1, "R1", "hold_empty after reset", hold_empty, 1);
    chk(tx_idle == 1'b1, "R1", "tx_idle after reset", tx_idle, 1);

    // R2 R3 R7 R9: 8 bits, no parity, one stop, divisor 1
    len_code = 2'd3; par_en = 0; stop_long = 0; divisor = 16'd1;
    send(8'hA5, 1'b1);
    wait_idle();

    // R4 R6: 5 bits, even parity, 1.5 stop, divisor 2
    len_code = 2'd0; par_en = 1; par_even = 1; par_stick = 0; stop_long = 1; divisor = 16'd2;
    send(8'h13, 1'b0);
    wait_idle();

    // R4 R6: 6 bits, odd parity, 2 stop
    len_code = 2'd1; par_even = 0;
    send(8'h2C, 1'b0);
    wait_idle();

    // R5: 7 bits, stick parity high then low, divisor 3
    len_code = 2'd2; par_stick = 1; par_even = 1; stop_long = 0; divisor = 16'd3;
    send(8'h55, 1'b0);
    wait_idle();
    par_even = 0;
    send(8'h7F, 1'b0);
    wait_idle();

    // R7: divisor 0 behaves as 1
    par_en = 0; par_stick = 0; len_code = 2'd3; divisor = 16'd0;
    send(8'h0F, 1'b0);
    wait_idle();

    // R10: overwrite of the waiting character
    divisor = 16'd1;
    send(8'h81, 1'b0);
    repeat (40) @(negedge clk);
    write_only(8'h66, 1'b0);
    send(8'h3E, 1'b0);
    chk(hold_empty == 1'b0, "R10", "holding full while busy", hold_empty, 0);
    wait_idle();

    // R8: break blocks loading and holds line low
    mon_en = 1'b0;
    @(negedge clk); #1 brk = 1'b1;
    repeat (3) @(negedge clk);
    send(8'hC3, 1'b0);
    repeat (60) @(negedge clk);
    chk(ser_out == 1'b0, "R8", "line low during break", ser_out, 0);
    chk(hold_empty == 1'b0, "R8", "character held during break", hold_empty, 0);
    chk(tx_idle == 1'b0, "R8", "tx_idle during pending break", tx_idle, 0);
    @(negedge clk); #1 brk = 1'b0; mon_en = 1'b1;
    wait_idle();

    // R11: loopback route, 6 bits even parity, divisor 3
    loop_sel = 1'b1; len_code = 2'd1; par_en = 1; par_even = 1; divisor = 16'd3;
    repeat (3) @(negedge clk);
    send(8'h3C, 1'b0);
    wait_idle();
    loop_sel = 1'b0;
    repeat (3) @(negedge clk);

    chk(q.size() == 0, "R2", "all expected frames seen", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule